// File: doc/BRIEF.md
# Online Core Self-Test Scheduler

This controller tests the cores of a multi-core system one at a time while the others keep running. It picks the next core in rotation, asks that core to isolate itself and waits for its acknowledgement. It then pulls stored test words from an external pattern memory into a small on-chip staging buffer and drives them into the selected core's scan port, comparing each response with the expected value carried in the same word. Finally it hands the core back to normal operation.

A core can refuse a test for now through its busy input, and the scheduler passes over it. A core that never acknowledges isolation is released after a fixed wait. A core that returns any wrong response keeps its isolate request and has its fail bit raised, so it stays out of service and out of the rotation until reset. New tests begin only while the run enable is high.

Top module: `core_selftest_sched`

## Requirements
- R1: While reset is held and right after it, no isolate request, no pattern-memory request and no scan beat is driven, and all fail bits are 0.
- R2: With run enable high and the scheduler idle, the next core tested is the first eligible core after the previously tested one, in ascending index order with wrap-around, starting at core 0 after reset. With run enable low, no new test starts.
- R3: A core whose busy input is high, or whose fail bit is set, is skipped in the rotation.
- R4: At most one core without a set fail bit has its isolate request raised at any time. All other cores' requests stay low.
- R5: No pattern-memory request and no scan beat occurs before the selected core has acknowledged isolation.
- R6: If the acknowledgement does not arrive, the isolate request is dropped after exactly ACK_TIMEOUT cycles high. No pattern is then fetched and the fail bit stays clear.
- R7: Each test reads pattern addresses 0 to PAT_COUNT-1 in ascending order, with at most one read outstanding. A read is issued only while the buffer holds fewer than BUF_DEPTH/2 words, so its fill never exceeds half depth.
- R8: Each test makes exactly PAT_COUNT scan beats, whose stimulus follows address order. A beat is held off (scan_valid low) while the buffer is empty.
- R9: A pattern word carries the stimulus in its upper DATA_W bits and the expected response in its lower DATA_W bits. Any beat whose scan_rsp differs from the expected field sets the fail bit of the core under test, which stays set until reset.
- R10: After the last beat, a core that passed has its isolate request dropped. A failed core keeps its request high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Allows a new test to start |
| core_busy | input | NUM_CORES | Per-core veto on being selected |
| iso_req | output | NUM_CORES | Per-core isolate request |
| iso_ack | input | NUM_CORES | Per-core isolation acknowledgement |
| mem_req | output | 1 | One-cycle read request to the pattern memory |
| mem_addr | output | ADDR_W | Pattern word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 2*DATA_W | Pattern word {stimulus, expected} |
| scan_valid | output | 1 | Scan beat strobe |
| scan_core | output | IDX_W | Index of the core receiving the beat |
| scan_stim | output | DATA_W | Scan stimulus |
| scan_rsp | input | DATA_W | Core response for the current beat |
| fail_flags | output | NUM_CORES | Sticky per-core failure bits |

## Verification
The rotation is exercised with all cores free, with one core vetoed and with a failed core left in the ring, so a wrong start point, a missing skip or a stale pointer each gives a different selection order. Tests are run with a short and with a long memory latency. The short latency lets the buffer stream smoothly. The long one forces empty-buffer stalls, which separates correct hold-off from dropped or repeated beats. A core that never acknowledges is used to tell the timeout path apart from a normal release. A single corrupted response on one core checks that the failure is caught, held and kept from the other cores.

// File: rtl/cst_pkg.sv
package cst_pkg;
  typedef enum logic [1:0] {
    PH_SELECT  = 2'd0,
    PH_ISOLATE = 2'd1,
    PH_APPLY   = 2'd2,
    PH_RESTORE = 2'd3
  } phase_t;
endpackage

// File: rtl/cst_rr_pick.sv
// Rotating search for the first eligible core after the last one served.
module cst_rr_pick #(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 2
) (
  input  logic [IDX_W-1:0]     last_idx,
  input  logic [NUM_CORES-1:0] eligible,
  output logic                 found,
  output logic [IDX_W-1:0]     pick_idx
);
  logic [IDX_W:0] cand;

  always_comb begin
    found    = 1'b0;
    pick_idx = last_idx;
    cand     = '0;
    for (int k = 1; k <= NUM_CORES; k++) begin
      cand = (IDX_W+1)'(last_idx) + (IDX_W+1)'(k);
      if (cand >= (IDX_W+1)'(NUM_CORES)) cand = cand - (IDX_W+1)'(NUM_CORES);
      if (!found && eligible[cand[IDX_W-1:0]]) begin
        found    = 1'b1;
        pick_idx = cand[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/cst_stage_buf.sv
// Staging buffer between the pattern memory and the scan port.
module cst_stage_buf #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] slots [DEPTH];
  logic [PW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign count   = cnt_q;
  assign rdata   = slots[rd_q];
  assign do_push = push && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop && !empty;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == PW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == PW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_q] <= wdata;
  end

  p_no_push_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q != CW'(DEPTH)));
  p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/cst_fetch.sv
// Issues single-outstanding reads that refill the buffer below half depth.
module cst_fetch #(
  parameter int PAT_COUNT = 12,
  parameter int BUF_DEPTH = 8,
  parameter int ADDR_W    = 8,
  localparam int CW       = $clog2(BUF_DEPTH + 1),
  localparam int BEAT_W   = $clog2(PAT_COUNT + 1),
  localparam int HALF     = BUF_DEPTH / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              active,
  input  logic [CW-1:0]     occupancy,
  input  logic              rvalid,
  output logic              req,
  output logic [ADDR_W-1:0] addr
);
  logic [BEAT_W-1:0] issued_q, issued_d;
  logic              pend_q, pend_d;

  assign req  = active && !pend_q && (issued_q < BEAT_W'(PAT_COUNT)) &&
                (occupancy < CW'(HALF));
  assign addr = ADDR_W'(issued_q);

  always_comb begin
    issued_d = issued_q;
    pend_d   = pend_q;
    if (clear) begin
      issued_d = '0;
    end else if (req) begin
      issued_d = issued_q + 1'b1;
    end
    if (req) pend_d = 1'b1;
    else if (rvalid) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issued_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      issued_q <= issued_d;
      pend_q   <= pend_d;
    end
  end

  p_req_spaced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  p_rsp_expected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> pend_q);
endmodule

// File: rtl/core_selftest_sched.sv
module core_selftest_sched
  import cst_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int DATA_W      = 16,
  parameter int BUF_DEPTH   = 8,
  parameter int PAT_COUNT   = 12,
  parameter int ACK_TIMEOUT = 16,
  parameter int ADDR_W      = 8,
  localparam int IDX_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int WORD_W     = 2 * DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_en,
  input  logic [NUM_CORES-1:0] core_busy,
  output logic [NUM_CORES-1:0] iso_req,
  input  logic [NUM_CORES-1:0] iso_ack,
  output logic                 mem_req,
  output logic [ADDR_W-1:0]    mem_addr,
  input  logic                 mem_rvalid,
  input  logic [WORD_W-1:0]    mem_rdata,
  output logic                 scan_valid,
  output logic [IDX_W-1:0]     scan_core,
  output logic [DATA_W-1:0]    scan_stim,
  input  logic [DATA_W-1:0]    scan_rsp,
  output logic [NUM_CORES-1:0] fail_flags
);
  localparam int CW     = $clog2(BUF_DEPTH + 1);
  localparam int TMR_W  = $clog2(ACK_TIMEOUT + 1);
  localparam int BEAT_W = $clog2(PAT_COUNT + 1);
  localparam int HALF   = BUF_DEPTH / 2;

  phase_t               phase_q, phase_d;
  logic [IDX_W-1:0]     cur_q, cur_d;
  logic [TMR_W-1:0]     timer_q, timer_d;
  logic [BEAT_W-1:0]    applied_q, applied_d;
  logic [NUM_CORES-1:0] iso_q, iso_d, fail_q, fail_d;

  logic                 pick_found;
  logic [IDX_W-1:0]     pick_idx;
  logic                 buf_pop, buf_empty;
  logic [WORD_W-1:0]    buf_word;
  logic [CW-1:0]        buf_count;
  logic                 mismatch;

  cst_rr_pick #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_pick (
    .last_idx (cur_q),
    .eligible (~core_busy & ~fail_q),
    .found    (pick_found),
    .pick_idx (pick_idx)
  );

  cst_stage_buf #(.WIDTH(WORD_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (mem_rvalid),
    .wdata (mem_rdata),
    .pop   (buf_pop),
    .rdata (buf_word),
    .empty (buf_empty),
    .count (buf_count)
  );

  cst_fetch #(.PAT_COUNT(PAT_COUNT), .BUF_DEPTH(BUF_DEPTH), .ADDR_W(ADDR_W)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (phase_q == PH_SELECT),
    .active    (phase_q == PH_APPLY),
    .occupancy (buf_count),
    .rvalid    (mem_rvalid),
    .req       (mem_req),
    .addr      (mem_addr)
  );

  assign scan_stim = buf_word[WORD_W-1:DATA_W];
  assign mismatch  = (scan_rsp != buf_word[DATA_W-1:0]);

  // Phase sequencing: select, isolate, apply, restore.
  always_comb begin
    phase_d   = phase_q;
    cur_d     = cur_q;
    timer_d   = timer_q;
    applied_d = applied_q;
    iso_d     = iso_q;
    fail_d    = fail_q;
    buf_pop   = 1'b0;
    case (phase_q)
      PH_SELECT: begin
        if (run_en && pick_found) begin
          cur_d     = pick_idx;
          iso_d     = iso_q | (NUM_CORES'(1) << pick_idx);
          timer_d   = '0;
          applied_d = '0;
          phase_d   = PH_ISOLATE;
        end
      end
      PH_ISOLATE: begin
        if (iso_ack[cur_q]) begin
          phase_d = PH_APPLY;
        end else if (timer_q == TMR_W'(ACK_TIMEOUT - 1)) begin
          iso_d[cur_q] = 1'b0;
          phase_d      = PH_SELECT;
        end else begin
          timer_d = timer_q + 1'b1;
        end
      end
      PH_APPLY: begin
        if (!buf_empty) begin
          buf_pop   = 1'b1;
          applied_d = applied_q + 1'b1;
          if (mismatch) fail_d[cur_q] = 1'b1;
          if (applied_q == BEAT_W'(PAT_COUNT - 1)) phase_d = PH_RESTORE;
        end
      end
      PH_RESTORE: begin
        if (!fail_q[cur_q]) iso_d[cur_q] = 1'b0;
        phase_d = PH_SELECT;
      end
      default: phase_d = PH_SELECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_SELECT;
      cur_q     <= IDX_W'(NUM_CORES - 1);
      timer_q   <= '0;
      applied_q <= '0;
      iso_q     <= '0;
      fail_q    <= '0;
    end else begin
      phase_q   <= phase_d;
      cur_q     <= cur_d;
      timer_q   <= timer_d;
      applied_q <= applied_d;
      iso_q     <= iso_d;
      fail_q    <= fail_d;
    end
  end

  assign iso_req    = iso_q;
  assign fail_flags = fail_q;
  assign scan_valid = buf_pop;
  assign scan_core  = cur_q;

  p_single_iso_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(iso_q & ~fail_q));
  p_scan_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scan_valid |-> (iso_req[cur_q] && iso_ack[cur_q]));
  p_fetch_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (iso_req[cur_q] && iso_ack[cur_q]));
  p_wait_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ISOLATE) |-> (timer_q < TMR_W'(ACK_TIMEOUT)));
  p_buf_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_count <= CW'(HALF));

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core_chk
    p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fail_q[g] |=> fail_q[g]);
    p_failed_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fail_q[g] |-> iso_q[g]);
  end
endmodule

// File: tb/core_selftest_sched_bench.sv
module core_selftest_sched_bench;
  localparam int N    = 4;
  localparam int DW   = 16;
  localparam int DEP  = 8;
  localparam int PAT  = 12;
  localparam int TO   = 16;
  localparam int AW   = 8;
  localparam int FBT  = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic run_en;
  logic [N-1:0] busy, iso_req, iso_ack, fail_flags, dead_mask, ack_p1;
  logic mem_req, mem_rvalid, scan_valid;
  logic [AW-1:0] mem_addr;
  logic [2*DW-1:0] mem_rdata;
  logic [1:0] scan_core;
  logic [DW-1:0] scan_stim, scan_rsp;

  int checks = 0, fails = 0;
  int mem_lat;
  logic fault_en;
  logic [1:0] fault_core;

  always #4 clk = ~clk;

  core_selftest_sched #(.NUM_CORES(N), .DATA_W(DW), .BUF_DEPTH(DEP), .PAT_COUNT(PAT),
                        .ACK_TIMEOUT(TO), .ADDR_W(AW)) u_core_selftest_sched (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .core_busy(busy),
    .iso_req(iso_req), .iso_ack(iso_ack), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .scan_valid(scan_valid),
    .scan_core(scan_core), .scan_stim(scan_stim), .scan_rsp(scan_rsp),
    .fail_flags(fail_flags));

  function automatic logic [DW-1:0] stim_of(input int a);
    return DW'(16'h1000 + a * 16'h0111);
  endfunction

  // Core model: acknowledge two cycles after request unless dead.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_p1  <= '0;
      iso_ack <= '0;
    end else begin
      ack_p1  <= iso_req & ~dead_mask;
      iso_ack <= ack_p1;
    end
  end
  assign scan_rsp = ~scan_stim ^
    ((fault_en && scan_core == fault_core && scan_stim == stim_of(FBT)) ? DW'(4) : DW'(0));

  // Pattern memory model, word = {stimulus, expected}.
  logic mem_pend;
  int   mem_cnt;
  logic [AW-1:0] mem_a;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_pend <= 1'b0; mem_cnt <= 0; mem_a <= '0; mem_rvalid <= 1'b0; mem_rdata <= '0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_req) begin
        mem_pend <= 1'b1; mem_cnt <= mem_lat; mem_a <= mem_addr;
      end else if (mem_pend) begin
        if (mem_cnt <= 1) begin
          mem_pend   <= 1'b0;
          mem_rvalid <= 1'b1;
          mem_rdata  <= {stim_of(int'(mem_a)), ~stim_of(int'(mem_a))};
        end else mem_cnt <= mem_cnt - 1;
      end
    end
  end

  // Monitor.
  logic [N-1:0] prev_iso = '0;
  int n_sel = 0, beats = 0, n_mreq = 0, exp_addr = 0;
  int bad_addr = 0, bad_stim = 0, v_r4 = 0, v_r5 = 0, dbl_req = 0, gaps = 0;
  int sel_log [64];
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < N; i++)
        if (iso_req[i] && !prev_iso[i]) begin
          sel_log[n_sel % 64] = i; n_sel++; beats = 0; exp_addr = 0;
        end
      if ($countones(iso_req & ~fail_flags) > 1) v_r4++;
      if ((mem_req || scan_valid) && ((iso_req & iso_ack) == '0)) v_r5++;
      if (mem_req) begin
        if (int'(mem_addr) != exp_addr) bad_addr++;
        if (mem_pend) dbl_req++;
        exp_addr++; n_mreq++;
      end
      if (scan_valid) begin
        if (scan_stim != stim_of(beats)) bad_stim++;
        beats++;
      end else if (beats > 0 && beats < PAT) gaps++;
    end
    prev_iso = iso_req;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(iso_req == '0 && mem_req == 1'b0 && scan_valid == 1'b0, "R1", "outputs in reset",
        int'({iso_req, mem_req, scan_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(fail_flags == '0 && iso_req == '0, "R1", "state after reset", int'({fail_flags, iso_req}), 0);
  endtask

  // mode: 0 pass, 1 timeout, 2 fail
  task automatic run_test(input int exp_core, input int mode, input logic [N-1:0] exp_fail,
                          input logic [N-1:0] held);
    int s_sel = n_sel, s_mreq = n_mreq, s_badd = bad_addr, s_bst = bad_stim;
    int s_r4 = v_r4, s_r5 = v_r5, s_dbl = dbl_req, got, cnt, w;
    run_en = 1'b1;
    w = 0;
    while (n_sel == s_sel && w < 200) begin @(negedge clk); #1; w++; end
    run_en = 1'b0;
    got = sel_log[s_sel % 64];
    chk(n_sel == s_sel + 1 && got == exp_core, "R2/R3", "selected core", got, exp_core);
    if (mode == 1) begin
      cnt = 1;
      while (iso_req[exp_core] && cnt < 100) begin @(negedge clk); #1; if (iso_req[exp_core]) cnt++; end
      chk(cnt == TO, "R6", "isolate cycles without ack", cnt, TO);
      chk(n_mreq == s_mreq, "R6", "fetches after timeout", n_mreq - s_mreq, 0);
      chk(fail_flags == exp_fail, "R6", "fail bits", int'(fail_flags), int'(exp_fail));
    end else begin
      w = 0;
      while (beats < PAT && w < 2000) begin @(negedge clk); #1; w++; end
      repeat (3) @(negedge clk); #1;
      chk(beats == PAT, "R8", "scan beats", beats, PAT);
      chk(bad_stim == s_bst, "R8", "out-of-order stimulus", bad_stim - s_bst, 0);
      chk(n_mreq - s_mreq == PAT && bad_addr == s_badd, "R7", "fetch count/order",
          n_mreq - s_mreq, PAT);
      chk(dbl_req == s_dbl, "R7", "reads while outstanding", dbl_req - s_dbl, 0);
      chk(v_r5 == s_r5, "R5", "activity before ack", v_r5 - s_r5, 0);
      chk(fail_flags == exp_fail, "R9", "fail bits", int'(fail_flags), int'(exp_fail));
      chk(iso_req == held, "R10", "isolate requests after test", int'(iso_req), int'(held));
    end
    chk(v_r4 == s_r4, "R4", "more than one core isolated", v_r4 - s_r4, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int s, g;
    run_en = 0; busy = '0; dead_mask = '0; mem_lat = 2; fault_en = 0; fault_core = 2'd2;
    t_reset();
    // R2: rotation from core 0
    run_test(0, 0, 4'b0000, 4'b0000);
    run_test(1, 0, 4'b0000, 4'b0000);
    run_test(2, 0, 4'b0000, 4'b0000);
    // R3: busy core 3 skipped
    busy = 4'b1000;
    run_test(0, 0, 4'b0000, 4'b0000);
    busy = '0;
    // R6: core 1 never acknowledges
    dead_mask = 4'b0010;
    run_test(1, 1, 4'b0000, 4'b0000);
    dead_mask = '0;
    // R9/R10: corrupted response on core 2
    fault_en = 1'b1;
    run_test(2, 2, 4'b0100, 4'b0100);
    fault_en = 1'b0;
    // R3: failed core 2 stays out of the ring
    run_test(3, 0, 4'b0100, 4'b0100);
    run_test(0, 0, 4'b0100, 4'b0100);
    run_test(1, 0, 4'b0100, 4'b0100);
    run_test(3, 0, 4'b0100, 4'b0100);
    // R8: slow memory forces buffer-empty stalls
    mem_lat = 7;
    g = gaps;
    run_test(0, 0, 4'b0100, 4'b0100);
    chk(gaps > g, "R8", "stall cycles with slow memory", gaps - g, 1);
    mem_lat = 2;
    // R2: run enable low starts nothing
    s = n_sel;
    repeat (40) @(negedge clk); #1;
    chk(n_sel == s, "R2", "tests started with run enable low", n_sel - s, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule